// File: doc/BRIEF.md
# Chainable Maskable Interrupt Controller

This block gathers interrupt requests from a set of frame-handling event inputs and from three internal timebases, and presents them to a CPU on one active-low, level-sensitive request line. The timebases are derived from the system clock. One ticks once per octet time at the configured bit rate, one every 1/32 ms, and one every 1 ms. Each event or tick sets a sticky bit in a status register. A mask register selects which of those bits may pull the request line low.

Software finds the source by reading the status register through a small host register port. It acknowledges a source by writing a one to that bit position. A masked source still records its event, so it can be polled. Several controllers can share one CPU line. Each controller takes the previous controller's request output on its chain input, and any low level there is passed straight through to its own output.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset the status register and the mask register both read zero, and irq_n follows chain_in_n alone.
- R2: A one-cycle pulse on frame_evt[k] sets status bit k+3 at the next clock edge. The bit stays set with no further events until it is cleared.
- R3: A host write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Address 1 holds the mask register. It is written whole by a host write and read back unchanged. A mask bit of 1 enables the matching status bit.
- R6: A status bit whose mask bit is 0 is still recorded in status but does not pull irq_n low.
- R7: irq_n is low while any status bit is set with its mask bit at 1. It returns high after the last such bit is cleared, provided chain_in_n is high.
- R8: A low level on chain_in_n drives irq_n low in the same cycle, whatever the status and mask hold.
- R9: Status bit 0 is set once per octet time, every 8*CLK_HZ/BIT_HZ clock cycles (1024 at the defaults).
- R10: Status bit 1 is set every CLK_HZ/32000 clock cycles (125 at the defaults).
- R11: Status bit 2 is set every CLK_HZ/1000 clock cycles (4000 at the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_evt | input | N_FRAME | One-cycle event pulses from frame logic |
| chain_in_n | input | 1 | Request from the upstream controller, active low |
| host_addr | input | 1 | Register select: 0 status, 1 mask |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | N_FRAME+3 | Write data: clear bits (status) or new value (mask) |
| host_rdata | output | N_FRAME+3 | Selected register contents |
| irq_n | output | 1 | Active-low level request toward the CPU or the next controller |

## Verification
The assertions run on every cycle. They cover the sticky set, clear and priority rules of each status bit, the single-cycle width and counter bounds of each timebase, the mask write path, and the rule that a low request is always explained by the chain input or by an enabled pending bit. Only the bench scenarios can show the exact tick periods of the three timebases, the bit positions software relies on, and that irq_n goes high again after an acknowledge. The same holds for a masked source staying silent while still being recorded.

// File: rtl/irq_pkg.sv
// Package: shared constants and helpers for the chained interrupt controller.
// Assumes clock and bit rates divide evenly into the tick periods.
package irq_pkg;
    localparam int NUM_TIMERS = 3;
    localparam int TB_OCTET   = 0;
    localparam int TB_SUBMS   = 1;
    localparam int TB_MS      = 2;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    // Clock cycles between ticks of timebase idx.
    function automatic int tick_div(int idx, int clk_hz, int bit_hz);
        case (idx)
            TB_OCTET: return (clk_hz / bit_hz) * 8;
            TB_SUBMS: return clk_hz / 32000;
            default:  return clk_hz / 1000;
        endcase
    endfunction
endpackage

// File: rtl/irq_tick_div.sv
// Module: free-running divider that emits a one-cycle pulse every DIV clocks.
// Assumes DIV >= 2. The pulse is registered, so it appears DIV cycles apart.
module irq_tick_div #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Register the terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= (cnt == LAST);
    end

    a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/irq_timebase.sv
// Module: the three timebases (octet, 1/32 ms, 1 ms) as tick pulses.
// Assumes CLK_HZ and BIT_HZ give integer divisors of at least 2.
module irq_timebase
    import irq_pkg::*;
#(
    parameter int CLK_HZ = 4_000_000,
    parameter int BIT_HZ = 31_250
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_TIMERS-1:0] ticks
);
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_div
        localparam int DIV_G = tick_div(g, CLK_HZ, BIT_HZ);
        irq_tick_div #(.DIV(DIV_G)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (ticks[g])
        );
    end
endmodule

// File: rtl/irq_status_bank.sv
// Module: sticky status bits with write-one-to-clear; a set wins over a clear.
// Assumes event inputs are single-cycle pulses in the clk domain.
module irq_status_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] clr_req,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold, set on event, clear on request when no event.
        always_ff @(posedge clk) begin
            if (!rst_n)          status[i] <= 1'b0;
            else if (set_evt[i]) status[i] <= 1'b1;
            else if (clr_req[i]) status[i] <= 1'b0;
        end

        a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !clr_req[i]) |=> status[i]);
        a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && !set_evt[i]) |=> !status[i]);
        a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[i] && set_evt[i]) |=> status[i]);
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
// Module: top of the chained maskable interrupt controller.
// Status bits [2:0] are the octet, 1/32 ms and 1 ms timers; the bits above
// them are frame events. irq_n merges the upstream chain request
// combinationally, so chain latency is zero.
module irq_chain_ctrl
    import irq_pkg::*;
#(
    parameter int N_FRAME = 5,
    parameter int CLK_HZ  = 4_000_000,
    parameter int BIT_HZ  = 31_250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_FRAME-1:0]   frame_evt,
    input  logic                 chain_in_n,
    input  logic                 host_addr,
    input  logic                 host_wr,
    input  logic [N_FRAME+2:0]   host_wdata,
    output logic [N_FRAME+2:0]   host_rdata,
    output logic                 irq_n
);
    localparam int NSRC = N_FRAME + NUM_TIMERS;

    logic [NUM_TIMERS-1:0] ticks;
    logic [NSRC-1:0]       events;
    logic [NSRC-1:0]       clr_req;
    logic [NSRC-1:0]       status;
    logic [NSRC-1:0]       mask;
    logic                  any_pending;

    irq_timebase #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .ticks(ticks)
    );

    // Gather timer ticks below the frame events.
    always_comb events = {frame_evt, ticks};

    // Decode write-one-to-clear requests.
    always_comb clr_req = (host_wr && host_addr == ADDR_STATUS) ? host_wdata : '0;

    irq_status_bank #(.W(NSRC)) u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(events),
        .clr_req(clr_req),
        .status (status)
    );

    // Mask register: full-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mask <= '0;
        else if (host_wr && host_addr == ADDR_MASK) mask <= host_wdata;
    end

    // Read mux.
    always_comb host_rdata = (host_addr == ADDR_MASK) ? mask : status;

    // Merge local enabled requests with the chain input.
    always_comb begin
        any_pending = |(status & mask);
        irq_n       = chain_in_n & ~any_pending;
    end

    a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_MASK) |=> mask == $past(host_wdata));
    a_r7_low_justified: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (!chain_in_n || (status & mask) != '0));
    a_r8_chain_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_in_n |-> !irq_n);
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_in_n && mask == '0) |-> irq_n);
endmodule

// File: tb/tb_irq_chain_ctrl.sv
module tb_irq_chain_ctrl;
    localparam int NF = 5;
    localparam int W  = NF + 3;
    localparam int DIV_OCT = 1024;
    localparam int DIV_SUB = 125;
    localparam int DIV_MS  = 4000;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NF-1:0] frame_evt = '0;
    logic          chain_in_n = 1;
    logic          host_addr = 0;
    logic          host_wr = 0;
    logic [W-1:0]  host_wdata = '0;
    logic [W-1:0]  host_rdata;
    logic          irq_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    irq_chain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_evt(frame_evt),
        .chain_in_n(chain_in_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_n(irq_n)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hang counts as a failure.
    always @(posedge clk) if (cyc == 150000) begin
        bad++; total++;
        $display("FAIL watchdog: act=%0d exp<%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [W-1:0] d);
        @(negedge clk); host_addr = a; host_wr = 1; host_wdata = d;
        @(negedge clk); host_wr = 0; host_wdata = '0;
    endtask

    task automatic rd(logic a, output logic [W-1:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    task automatic pulse(logic [NF-1:0] e);
        @(negedge clk); frame_evt = e;
        @(negedge clk); frame_evt = '0;
    endtask

    task automatic t_reset;
        logic [W-1:0] d;
        rd(1'b0, d); check("R1 status", d, '0);
        rd(1'b1, d); check("R1 mask", d, '0);
        check("R1 irq_n", irq_n, 1);
    endtask

    task automatic t_sticky;
        logic [W-1:0] d;
        pulse(5'b00101);
        repeat (3) @(negedge clk);
        rd(1'b0, d); check("R2 frame bits", d[W-1:3], 5'b00101);
        wr(1'b0, 8'b0001_0000);            // R3: clear frame bit 1 (status bit 4) only
        rd(1'b0, d); check("R3 partial clear", d[W-1:3], 5'b00101);
        wr(1'b0, 8'b0000_1000);
        rd(1'b0, d); check("R3 clear one", d[W-1:3], 5'b00100);
        wr(1'b0, 8'b1111_1000);
        rd(1'b0, d); check("R3 clear all", d[W-1:3], 5'b00000);
    endtask

    task automatic t_set_wins;
        logic [W-1:0] d;
        @(negedge clk); host_addr = 0; host_wr = 1; host_wdata = 8'b1000_0000;
        frame_evt = 5'b10000;
        @(negedge clk); host_wr = 0; host_wdata = '0; frame_evt = '0;
        rd(1'b0, d); check("R4 event beats clear", d[7], 1);
        wr(1'b0, 8'b1000_0000);
        rd(1'b0, d); check("R4 later clear", d[7], 0);
    endtask

    task automatic t_mask;
        logic [W-1:0] d;
        wr(1'b1, 8'b1010_0000);
        rd(1'b1, d); check("R5 mask readback", d, 8'b1010_0000);
        pulse(5'b01000);                    // status bit 6, masked
        rd(1'b0, d); check("R6 masked recorded", d[6], 1);
        check("R6 masked silent", irq_n, 1);
        pulse(5'b00100);                    // status bit 5, enabled
        check("R7 irq low", irq_n, 0);
        wr(1'b0, 8'b0010_0000);
        check("R7 irq released", irq_n, 1);
        wr(1'b0, 8'b0100_0000);
        wr(1'b1, 8'h00);
    endtask

    task automatic t_chain;
        @(negedge clk); chain_in_n = 0; #1;
        check("R8 chain low", irq_n, 0);
        chain_in_n = 1; #1;
        check("R8 chain high", irq_n, 1);
    endtask

    task automatic period(string req, int b, int exp);
        logic [W-1:0] d;
        int t1;
        wr(1'b0, W'(1) << b);
        do begin @(negedge clk); rd(1'b0, d); end while (!d[b]);
        t1 = cyc;
        wr(1'b0, W'(1) << b);
        do begin @(negedge clk); rd(1'b0, d); end while (!d[b]);
        check(req, cyc - t1, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_set_wins();
        t_mask();
        t_chain();
        period("R9 octet period", 0, DIV_OCT);
        period("R10 sub-ms period", 1, DIV_SUB);
        period("R11 ms period", 2, DIV_MS);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule